// File: doc/BRIEF.md
# Protection Key Permission Gate

This block decides, in the same cycle, whether a memory access may proceed under a per-thread table of protection-key permissions. Every page carries a 4-bit key. Each hardware thread owns a 32-bit permission word that holds two bits for each of the 16 keys. One bit blocks all data access through that key. The other bit blocks only data writes. Software loads a thread's word through a write port and reads it back through a read port. A write becomes visible to checks from the following clock edge.

A check request carries five things: the key, a write flag, a fetch flag, the thread number and a flag that says the core is in 64-bit mode. The response is combinational from the request: an allow/fault bit and a 2-bit reason. The check path uses valid/ready. `rsp_valid` follows `req_valid`, and `req_ready` follows `rsp_ready`. A request is consumed only in a cycle where both valid and ready are high. If the consumer holds `rsp_ready` low, the requester must hold its request stable, and the response stays stable with it. The register ports are plain control pins with no handshake.

Top module: `pkey_gate`

## Requirements
- R1: After reset, every thread's permission word reads as all zeros, and every check returns reason 00 (allowed).
- R2: For key k, word bit 2k is the access-block bit and bit 2k+1 is the write-block bit. A write stores `wr_data` into the word of `wr_thread`, and `rd_data` returns the word of `rd_thread`.
- R3: A check and a read use only the word of the thread they name. A write to one thread leaves every other thread's word unchanged.
- R4: When the key's access-block bit is set, a data read and a data write both return reason 01 (access fault).
- R5: When only the key's write-block bit is set, a data write returns reason 10 (write fault) and a data read returns 00.
- R6: When both bits of the key are set, the reason is 01. Reason 10 appears only for a write request.
- R7: A request with the fetch flag set always returns 00, whatever the word holds.
- R8: A request with the 64-bit mode flag clear always returns 00.
- R9: A write takes effect from the next clock edge. A check or read in the same cycle as the write sees the old word.
- R10: `rsp_fault` is 1 exactly when the reason is not 00, and reason 11 never occurs. `rsp_valid` equals `req_valid`, and `req_ready` equals `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Load a permission word |
| wr_thread | input | 1 | Thread whose word is loaded |
| wr_data | input | 32 | New permission word |
| rd_thread | input | 1 | Thread whose word is read |
| rd_data | output | 32 | Current word of rd_thread |
| req_valid | input | 1 | Check request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_key | input | 4 | Protection key from the page entry |
| req_write | input | 1 | 1 = data write, 0 = data read |
| req_fetch | input | 1 | Instruction fetch |
| req_thread | input | 1 | Requesting thread |
| req_long_mode | input | 1 | 64-bit mode flag |
| rsp_valid | output | 1 | Check result present |
| rsp_ready | input | 1 | Consumer accepts result |
| rsp_fault | output | 1 | Access denied |
| rsp_reason | output | 2 | 00 ok, 01 access fault, 10 write fault |

## Verification
The bench targets the following corner cases:
- A key with both bits set. A gate that ranks the write bit first would report 10 here.
- Fetches and requests with 64-bit mode clear, on words full of set bits. A gate that ignores either exemption would fault them.
- A check issued in the same cycle as a write to its own thread. A bypassed register would already show the new word.
- Writes to thread 0 followed by checks on thread 1. A shared word or a wrong thread decode would leak between the threads.
- The highest and lowest keys. An off-by-one in the bit-pair index would read a neighbouring key's bits.

// File: rtl/pkey_gate_pkg.sv
package pkey_gate_pkg;
  typedef enum logic [1:0] {
    RSN_OK = 2'b00,
    RSN_AD = 2'b01,
    RSN_WD = 2'b10
  } reason_t;
endpackage

// File: rtl/pkey_gate_bank.sv
module pkey_gate_bank #(
  parameter int NUM_THREADS = 2,
  parameter int REG_W       = 32,
  parameter int TID_W       = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TID_W-1:0] wr_thread,
  input  logic [REG_W-1:0] wr_data,
  input  logic [TID_W-1:0] rd_thread,
  input  logic [TID_W-1:0] chk_thread,
  output logic [REG_W-1:0] rd_word,
  output logic [REG_W-1:0] chk_word
);
  logic [REG_W-1:0] words [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[t] <= '0;
      else if (wr_en && (wr_thread == TID_W'(t)))
        words[t] <= wr_data;
    end
  end

  assign rd_word  = words[rd_thread];
  assign chk_word = words[chk_thread];
endmodule

// File: rtl/pkey_gate_decode.sv
module pkey_gate_decode #(
  parameter int NUM_KEYS = 16,
  parameter int KEY_W    = 4
) (
  input  logic [2*NUM_KEYS-1:0] word,
  input  logic [KEY_W-1:0]      key,
  output logic                  acc_block,
  output logic                  wr_block
);
  logic [NUM_KEYS-1:0] acc_vec;
  logic [NUM_KEYS-1:0] wr_vec;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign acc_vec[k] = word[2*k];
    assign wr_vec[k]  = word[2*k+1];
  end

  assign acc_block = acc_vec[key];
  assign wr_block  = wr_vec[key];
endmodule

// File: rtl/pkey_gate_classify.sv
module pkey_gate_classify
  import pkey_gate_pkg::*;
(
  input  logic    acc_block,
  input  logic    wr_block,
  input  logic    is_write,
  input  logic    is_fetch,
  input  logic    long_mode,
  output reason_t reason
);
  logic enforced;

  assign enforced = long_mode && !is_fetch;

  always_comb begin
    reason = RSN_OK;
    if (enforced) begin
      if (acc_block)
        reason = RSN_AD;
      else if (wr_block && is_write)
        reason = RSN_WD;
    end
  end
endmodule

// File: rtl/pkey_gate.sv
module pkey_gate
  import pkey_gate_pkg::*;
#(
  parameter int NUM_KEYS    = 16,
  parameter int NUM_THREADS = 2,
  localparam int KEY_W      = $clog2(NUM_KEYS),
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int REG_W      = 2 * NUM_KEYS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TID_W-1:0] wr_thread,
  input  logic [REG_W-1:0] wr_data,
  input  logic [TID_W-1:0] rd_thread,
  output logic [REG_W-1:0] rd_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [KEY_W-1:0] req_key,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic [TID_W-1:0] req_thread,
  input  logic             req_long_mode,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [1:0]       rsp_reason
);
  logic [REG_W-1:0] chk_word;
  logic             acc_block;
  logic             wr_block;
  reason_t          reason;

  pkey_gate_bank #(
    .NUM_THREADS(NUM_THREADS), .REG_W(REG_W), .TID_W(TID_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_thread(wr_thread), .wr_data(wr_data),
    .rd_thread(rd_thread), .chk_thread(req_thread),
    .rd_word(rd_data), .chk_word(chk_word)
  );

  pkey_gate_decode #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W)) u_dec (
    .word(chk_word), .key(req_key),
    .acc_block(acc_block), .wr_block(wr_block)
  );

  pkey_gate_classify u_cls (
    .acc_block(acc_block), .wr_block(wr_block),
    .is_write(req_write), .is_fetch(req_fetch), .long_mode(req_long_mode),
    .reason(reason)
  );

  assign rsp_valid  = req_valid;
  assign req_ready  = rsp_ready;
  assign rsp_reason = reason;
  assign rsp_fault  = (reason != RSN_OK);
endmodule

// File: rtl/pkey_gate_chk.sv
module pkey_gate_chk #(
  parameter int NUM_KEYS    = 16,
  parameter int NUM_THREADS = 2,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int REG_W      = 2 * NUM_KEYS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [TID_W-1:0] wr_thread,
  input logic [REG_W-1:0] wr_data,
  input logic [TID_W-1:0] rd_thread,
  input logic [REG_W-1:0] rd_data,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             req_fetch,
  input logic             req_long_mode,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_fault,
  input logic [1:0]       rsp_reason
);
  AST_FETCH_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_fetch |-> rsp_reason == 2'b00); // R7
  AST_MODE_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_long_mode |-> rsp_reason == 2'b00); // R8
  AST_WD_ONLY_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reason == 2'b10 |-> req_write); // R6
  AST_NO_RSV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reason != 2'b11); // R10
  AST_FAULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault == (rsp_reason != 2'b00)); // R10
  AST_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid == req_valid) && (req_ready == rsp_ready)); // R10
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) && (rd_thread == $past(wr_thread)) |-> rd_data == $past(wr_data)); // R9
endmodule

bind pkey_gate pkey_gate_chk #(.NUM_KEYS(NUM_KEYS), .NUM_THREADS(NUM_THREADS)) u_chk (.*);

// File: tb/pkey_gate_test.sv
`timescale 1ns/1ps
module pkey_gate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_thread = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_thread = 1'b0;
  logic [31:0] rd_data;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_key = '0;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic        req_thread = 1'b0;
  logic        req_long_mode = 1'b1;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [1:0]  rsp_reason;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [31:0] model [2];

  always #2 clk = ~clk;

  pkey_gate uut (.*);

  function automatic logic [1:0] exp_reason(logic [31:0] w, logic [3:0] k,
                                            logic wr, logic f, logic lm);
    if (f || !lm) return 2'b00;
    if (w[2*k]) return 2'b01;
    if (w[2*k+1] && wr) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare outputs mid-cycle, then let the edge pass and update the model
  task automatic step(string tag);
    logic [1:0] er;
    #1;
    er = exp_reason(model[req_thread], req_key, req_write, req_fetch, req_long_mode);
    check(tag, 32'(rsp_reason), 32'(er));
    check("R10", 32'(rsp_fault), 32'(er != 2'b00));
    check("R10", 32'({rsp_valid, req_ready}), 32'({req_valid, rsp_ready}));
    check("R2", rd_data, model[rd_thread]);
    @(posedge clk);
    if (wr_en) model[wr_thread] = wr_data;
    @(negedge clk);
  endtask

  task automatic req(logic [3:0] k, logic wr, logic f, logic t, logic lm);
    req_valid = 1'b1; req_key = k; req_write = wr; req_fetch = f;
    req_thread = t; req_long_mode = lm;
  endtask

  initial begin
    model[0] = '0; model[1] = '0;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: cleared state
    rd_thread = 1'b0; #1; check("R1", rd_data, 32'h0);
    rd_thread = 1'b1; #1; check("R1", rd_data, 32'h0);
    req(4'd15, 1'b1, 1'b0, 1'b1, 1'b1); step("R1");

    // R9: same-cycle write is not seen, next cycle it is
    wr_en = 1'b1; wr_thread = 1'b0; wr_data = 32'h0000_00C0; rd_thread = 1'b0;
    req(4'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    #1; check("R9", 32'(rsp_reason), 32'h0); check("R9", rd_data, 32'h0);
    step("R9");
    wr_en = 1'b0;
    #1; check("R9", 32'(rsp_reason), 32'h1); check("R9", rd_data, 32'h0000_00C0);
    step("R6");

    // R3: thread 1 untouched
    req(4'd3, 1'b1, 1'b0, 1'b1, 1'b1); rd_thread = 1'b1;
    #1; check("R3", 32'(rsp_reason), 32'h0); check("R3", rd_data, 32'h0);
    step("R3");

    // R4, R5: boundary keys 0 and 15
    wr_en = 1'b1; wr_thread = 1'b1; wr_data = 32'h8000_0001; step("R2");
    wr_en = 1'b0;
    req(4'd0, 1'b0, 1'b0, 1'b1, 1'b1); #1; check("R4", 32'(rsp_reason), 32'h1); step("R4");
    req(4'd0, 1'b1, 1'b0, 1'b1, 1'b1); #1; check("R4", 32'(rsp_reason), 32'h1); step("R4");
    req(4'd15, 1'b1, 1'b0, 1'b1, 1'b1); #1; check("R5", 32'(rsp_reason), 32'h2); step("R5");
    req(4'd15, 1'b0, 1'b0, 1'b1, 1'b1); #1; check("R5", 32'(rsp_reason), 32'h0); step("R5");

    // R7, R8: exemptions on an all-ones word
    wr_en = 1'b1; wr_thread = 1'b0; wr_data = 32'hFFFF_FFFF; step("R2");
    wr_en = 1'b0;
    req(4'd7, 1'b1, 1'b1, 1'b0, 1'b1); #1; check("R7", 32'(rsp_reason), 32'h0); step("R7");
    req(4'd7, 1'b1, 1'b0, 1'b0, 1'b0); #1; check("R8", 32'(rsp_reason), 32'h0); step("R8");

    // R10: back-pressure
    rsp_ready = 1'b0; req(4'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    #1; check("R10", 32'(req_ready), 32'h0); step("R10");
    rsp_ready = 1'b1; req_valid = 1'b0;
    #1; check("R10", 32'(rsp_valid), 32'h0); step("R10");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      string tag;
      logic [1:0] er;
      wr_en = ($urandom % 4) == 0;
      wr_thread = $urandom % 2;
      wr_data = $urandom;
      rd_thread = $urandom % 2;
      rsp_ready = ($urandom % 8) != 0;
      req($urandom % 16, $urandom % 2, ($urandom % 8) == 0, $urandom % 2,
          ($urandom % 8) != 0);
      er = exp_reason(model[req_thread], req_key, req_write, req_fetch, req_long_mode);
      if (req_fetch) tag = "R7";
      else if (!req_long_mode) tag = "R8";
      else if (er == 2'b01 && model[req_thread][2*req_key+1]) tag = "R6";
      else if (er == 2'b01) tag = "R4";
      else if (model[req_thread][2*req_key+1]) tag = "R5";
      else tag = "R3";
      step(tag);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule